// File: doc/BRIEF.md
# Address-Sequence Store/Recall Command Detector

This block sits beside the bus logic of a memory port with a 13-bit address and watches the accesses made to it. Each qualified access reaches the block as a single-clock strobe. The strobe comes with the access address and with the level of the active-low write enable, so a high level marks a read. When software makes a fixed run of six reads, the block issues a command to the nonvolatile sequencer. The first five reads must hit five fixed prefix addresses in a fixed order. The sixth read then selects the command: `0F0F` requests a store and `0F0E` requests a recall.

The command arrives as a one-clock pulse on `store_pulse` or `recall_pulse`, registered one clock after the sixth strobe. During the sixth access the block also raises `out_hiz`, combinationally, so the bus logic turns the data drivers off for that access. A write, a read of the wrong address or a busy sequencer all break a sequence that is in progress. A read of `0000` that breaks a sequence counts at once as the first step of a new one.

Top module: `seq_cmd_detect`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, `store_pulse`, `recall_pulse` and `out_hiz` are low. Any partial sequence is dropped, so a key read that comes right after reset issues no command.
- R2: After reads at `0000`, `1555`, `0AAA`, `1FFF` and `10F0` with no other strobe between them, a read at `0F0F` makes `store_pulse` high for exactly the clock after that strobe.
- R3: The same prefix followed by a read at `0F0E` makes `recall_pulse` high for exactly the clock after that strobe.
- R4: `out_hiz` is high during the sixth, command-issuing strobe and low during the five prefix reads.
- R5: A strobe with `acc_we_n` low (a write) at any step aborts the sequence, and this includes a write to the key address. No command is issued and `out_hiz` stays low.
- R6: A read strobe at an address other than the next expected one aborts the sequence, and the later reads of that run issue no command.
- R7: When a read of `0000` breaks a sequence, it counts as the first step, so five more correct reads complete the command.
- R8: Cycles with `acc_strobe` low do not advance or abort the sequence, whatever the address is in those cycles.
- R9: While `seq_busy` is high, strobes are ignored and the detector returns to idle. `out_hiz` stays low and no pulse follows.
- R10: `store_pulse` and `recall_pulse` are never high together, and each is high for a single clock.
- R11: A sixth read at an address that is neither `0F0F` nor `0F0E` issues no command and leaves the detector idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_strobe | input | 1 | One-clock strobe for each chip-enable-controlled access |
| acc_we_n | input | 1 | Write-enable level of the access (1 = read, 0 = write) |
| acc_addr | input | 13 | Access address |
| seq_busy | input | 1 | Sequencer busy: strobes are ignored and the detector is held idle |
| out_hiz | output | 1 | Turn the data outputs off for the current access (the sixth, command step) |
| store_pulse | output | 1 | One-clock store command |
| recall_pulse | output | 1 | One-clock recall command |

## Verification
The hardest state to reach from the ports is a broken sequence that must restart from the same access. This happens when `0000` is read in the middle of a run, and it is separate from a plain abort to idle. A related hard case is a sequence that is cut short only at its last step, by a write, a busy cycle or a near-miss key. The stimulus table builds the five-read prefix many times over and places the fault at a chosen step each time. It then carries on with the correct reads, so the command must appear only where the restart rule permits it. Gaps with the strobe low, carrying addresses that would otherwise abort the run, are placed between real steps to show that the address alone does not count as an access.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int ADDR_W     = 13;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam addr_t STORE_KEY  = 13'h0F0F;
    localparam addr_t RECALL_KEY = 13'h0F0E;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef struct packed {
        logic  strobe;
        logic  read;
        addr_t addr;
    } access_t;

    typedef struct packed {
        logic prefix_hit;
        logic is_start;
        cmd_e final_cmd;
    } match_t;

    // Ordered prefix addresses; the order is the protocol.
    function automatic addr_t prefix_addr(input int idx);
        case (idx)
            0:       return 13'h0000;
            1:       return 13'h1555;
            2:       return 13'h0AAA;
            3:       return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    function automatic logic is_final_step(input step_t s);
        return s == step_t'(PREFIX_LEN);
    endfunction

endpackage

// File: rtl/seqdet_match.sv
module seqdet_match
    import seqdet_pkg::*;
(
    input  access_t acc,
    input  step_t   step,
    output match_t  m
);

    logic [PREFIX_LEN-1:0] hit;

    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
        assign hit[g] = (acc.addr == prefix_addr(g));
    end

    always_comb begin
        m          = '0;
        m.is_start = hit[0];
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (step == step_t'(i)) begin
                m.prefix_hit = hit[i];
            end
        end
        if (is_final_step(step)) begin
            if (acc.addr == STORE_KEY) begin
                m.final_cmd = CMD_STORE;
            end else if (acc.addr == RECALL_KEY) begin
                m.final_cmd = CMD_RECALL;
            end
        end
    end

endmodule

// File: rtl/seqdet_ctrl.sv
module seqdet_ctrl
    import seqdet_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  access_t acc,
    input  match_t  m,
    output step_t   step,
    output cmd_e    fire,
    output logic    hiz
);

    step_t step_q;
    step_t step_nxt;
    step_t restart_step;

    assign restart_step = m.is_start ? step_t'(1) : step_t'(0);

    always_comb begin
        step_nxt = step_q;
        fire     = CMD_NONE;
        if (busy) begin
            step_nxt = '0;
        end else if (acc.strobe) begin
            if (!acc.read) begin
                step_nxt = '0;
            end else if (is_final_step(step_q)) begin
                fire     = m.final_cmd;
                step_nxt = restart_step;
            end else if (m.prefix_hit) begin
                step_nxt = step_t'(step_q + 1'b1);
            end else begin
                step_nxt = restart_step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else begin
            step_q <= step_nxt;
        end
    end

    assign step = step_q;
    assign hiz  = (fire != CMD_NONE);

endmodule

// File: rtl/seqdet_cmd_out.sv
module seqdet_cmd_out
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e fire,
    output logic store_pulse,
    output logic recall_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_pulse  <= 1'b0;
            recall_pulse <= 1'b0;
        end else begin
            store_pulse  <= (fire == CMD_STORE);
            recall_pulse <= (fire == CMD_RECALL);
        end
    end

endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
    import seqdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_strobe,
    input  logic              acc_we_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              seq_busy,
    output logic              out_hiz,
    output logic              store_pulse,
    output logic              recall_pulse
);

    access_t acc;
    match_t  m;
    step_t   step;
    cmd_e    fire;

    assign acc.strobe = acc_strobe;
    assign acc.read   = acc_we_n;
    assign acc.addr   = acc_addr;

    seqdet_match u_match (
        .acc  (acc),
        .step (step),
        .m    (m)
    );

    seqdet_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .busy (seq_busy),
        .acc  (acc),
        .m    (m),
        .step (step),
        .fire (fire),
        .hiz  (out_hiz)
    );

    seqdet_cmd_out u_out (
        .clk          (clk),
        .rst          (rst),
        .fire         (fire),
        .store_pulse  (store_pulse),
        .recall_pulse (recall_pulse)
    );

endmodule

// File: rtl/seq_cmd_detect_chk.sv
module seq_cmd_detect_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_strobe,
    input logic        acc_we_n,
    input logic [12:0] acc_addr,
    input logic        seq_busy,
    input logic        out_hiz,
    input logic        store_pulse,
    input logic        recall_pulse
);

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(store_pulse && recall_pulse)); // R10

    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        store_pulse |=> !store_pulse); // R10

    AST_STORE_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
        store_pulse |-> ($past(out_hiz) && $past(acc_addr) == 13'h0F0F)); // R2

    AST_RECALL_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
        recall_pulse |-> ($past(out_hiz) && $past(acc_addr) == 13'h0F0E)); // R3

    AST_HIZ_GIVES_CMD: assert property (@(posedge clk) disable iff (rst)
        out_hiz |=> (store_pulse || recall_pulse)); // R4

    AST_WRITE_NO_HIZ: assert property (@(posedge clk) disable iff (rst)
        (acc_strobe && !acc_we_n) |-> !out_hiz); // R5

    AST_IDLE_NO_HIZ: assert property (@(posedge clk) disable iff (rst)
        !acc_strobe |-> !out_hiz); // R8

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        seq_busy |=> (!store_pulse && !recall_pulse)); // R9

endmodule

bind seq_cmd_detect seq_cmd_detect_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_strobe   (acc_strobe),
    .acc_we_n     (acc_we_n),
    .acc_addr     (acc_addr),
    .seq_busy     (seq_busy),
    .out_hiz      (out_hiz),
    .store_pulse  (store_pulse),
    .recall_pulse (recall_pulse)
);

// File: tb/seq_cmd_detect_tb.sv
module seq_cmd_detect_tb;

    localparam int CLK_HALF = 10; // 50 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_strobe = 1'b0;
    logic        acc_we_n = 1'b1;
    logic [12:0] acc_addr = '0;
    logic        seq_busy = 1'b0;
    logic        out_hiz;
    logic        store_pulse;
    logic        recall_pulse;

    int checks = 0;
    int fails  = 0;

    always #(CLK_HALF) clk = ~clk;

    seq_cmd_detect u_dut (
        .clk          (clk),
        .rst          (rst),
        .acc_strobe   (acc_strobe),
        .acc_we_n     (acc_we_n),
        .acc_addr     (acc_addr),
        .seq_busy     (seq_busy),
        .out_hiz      (out_hiz),
        .store_pulse  (store_pulse),
        .recall_pulse (recall_pulse)
    );

    // {strobe, we_n, busy, addr[12:0], exp_hiz, exp_store, exp_recall, req[3:0]}
    localparam int NV = 63;
    localparam logic [22:0] VEC [NV] = '{
        // R2 / R4: store run
        {3'b110, 13'h0000, 3'b000, 4'd4},
        {3'b110, 13'h1555, 3'b000, 4'd4},
        {3'b110, 13'h0AAA, 3'b000, 4'd4},
        {3'b110, 13'h1FFF, 3'b000, 4'd4},
        {3'b110, 13'h10F0, 3'b000, 4'd4},
        {3'b110, 13'h0F0F, 3'b110, 4'd2},
        {3'b010, 13'h0F0F, 3'b000, 4'd10}, // R10: pulse lasts one clock
        // R3: recall run
        {3'b110, 13'h0000, 3'b000, 4'd3},
        {3'b110, 13'h1555, 3'b000, 4'd3},
        {3'b110, 13'h0AAA, 3'b000, 4'd3},
        {3'b110, 13'h1FFF, 3'b000, 4'd3},
        {3'b110, 13'h10F0, 3'b000, 4'd3},
        {3'b110, 13'h0F0E, 3'b101, 4'd3},
        // R6: wrong address mid-run
        {3'b110, 13'h0000, 3'b000, 4'd6},
        {3'b110, 13'h1555, 3'b000, 4'd6},
        {3'b110, 13'h0AAA, 3'b000, 4'd6},
        {3'b110, 13'h1234, 3'b000, 4'd6},
        {3'b110, 13'h1FFF, 3'b000, 4'd6},
        {3'b110, 13'h10F0, 3'b000, 4'd6},
        {3'b110, 13'h0F0F, 3'b000, 4'd6},
        // R5: write in the prefix
        {3'b110, 13'h0000, 3'b000, 4'd5},
        {3'b110, 13'h1555, 3'b000, 4'd5},
        {3'b100, 13'h0AAA, 3'b000, 4'd5},
        {3'b110, 13'h0AAA, 3'b000, 4'd5},
        {3'b110, 13'h1FFF, 3'b000, 4'd5},
        {3'b110, 13'h10F0, 3'b000, 4'd5},
        {3'b110, 13'h0F0F, 3'b000, 4'd5},
        // R5: write at the key step
        {3'b110, 13'h0000, 3'b000, 4'd5},
        {3'b110, 13'h1555, 3'b000, 4'd5},
        {3'b110, 13'h0AAA, 3'b000, 4'd5},
        {3'b110, 13'h1FFF, 3'b000, 4'd5},
        {3'b110, 13'h10F0, 3'b000, 4'd5},
        {3'b100, 13'h0F0F, 3'b000, 4'd5},
        // R7: 0000 breaks a run and restarts it
        {3'b110, 13'h0000, 3'b000, 4'd7},
        {3'b110, 13'h1555, 3'b000, 4'd7},
        {3'b110, 13'h0000, 3'b000, 4'd7},
        {3'b110, 13'h1555, 3'b000, 4'd7},
        {3'b110, 13'h0AAA, 3'b000, 4'd7},
        {3'b110, 13'h1FFF, 3'b000, 4'd7},
        {3'b110, 13'h10F0, 3'b000, 4'd7},
        {3'b110, 13'h0F0F, 3'b110, 4'd7},
        // R8: gaps with strobe low carry stray addresses
        {3'b110, 13'h0000, 3'b000, 4'd8},
        {3'b010, 13'h1234, 3'b000, 4'd8},
        {3'b110, 13'h1555, 3'b000, 4'd8},
        {3'b010, 13'h0F0F, 3'b000, 4'd8},
        {3'b110, 13'h0AAA, 3'b000, 4'd8},
        {3'b110, 13'h1FFF, 3'b000, 4'd8},
        {3'b110, 13'h10F0, 3'b000, 4'd8},
        {3'b010, 13'h0F0E, 3'b000, 4'd8},
        {3'b110, 13'h0F0E, 3'b101, 4'd8},
        // R9: busy drops the run
        {3'b110, 13'h0000, 3'b000, 4'd9},
        {3'b110, 13'h1555, 3'b000, 4'd9},
        {3'b110, 13'h0AAA, 3'b000, 4'd9},
        {3'b110, 13'h1FFF, 3'b000, 4'd9},
        {3'b111, 13'h10F0, 3'b000, 4'd9},
        {3'b110, 13'h10F0, 3'b000, 4'd9},
        {3'b110, 13'h0F0F, 3'b000, 4'd9},
        // R11: near-miss key
        {3'b110, 13'h0000, 3'b000, 4'd11},
        {3'b110, 13'h1555, 3'b000, 4'd11},
        {3'b110, 13'h0AAA, 3'b000, 4'd11},
        {3'b110, 13'h1FFF, 3'b000, 4'd11},
        {3'b110, 13'h10F0, 3'b000, 4'd11},
        {3'b110, 13'h0F0D, 3'b000, 4'd11}
    };

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check out_hiz mid-cycle, then check pulses one clock later.
    task automatic do_acc(input logic s, input logic we_n, input logic b, input logic [12:0] a,
                          input logic e_hiz, input logic e_st, input logic e_rc, input int req);
        acc_strobe = s;
        acc_we_n   = we_n;
        seq_busy   = b;
        acc_addr   = a;
        #(CLK_HALF / 2);
        check(out_hiz == e_hiz, req, "out_hiz", int'(out_hiz), int'(e_hiz));
        @(posedge clk);
        @(negedge clk);
        check(store_pulse == e_st, req, "store_pulse", int'(store_pulse), int'(e_st));
        check(recall_pulse == e_rc, req, "recall_pulse", int'(recall_pulse), int'(e_rc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, even with a key read presented
        rst = 1'b1;
        @(negedge clk);
        acc_strobe = 1'b1;
        acc_addr   = 13'h0F0F;
        #(CLK_HALF / 2);
        check(out_hiz == 1'b0, 1, "out_hiz in reset", int'(out_hiz), 0);
        @(negedge clk);
        check(store_pulse == 1'b0, 1, "store_pulse in reset", int'(store_pulse), 0);
        check(recall_pulse == 1'b0, 1, "recall_pulse in reset", int'(recall_pulse), 0);
        acc_strobe = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_acc(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:7],
                   VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
        end

        // R1: reset in the middle of a run discards the prefix
        do_acc(1'b1, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b0, 1'b0, 1);
        do_acc(1'b1, 1'b1, 1'b0, 13'h1555, 1'b0, 1'b0, 1'b0, 1);
        do_acc(1'b1, 1'b1, 1'b0, 13'h0AAA, 1'b0, 1'b0, 1'b0, 1);
        do_acc(1'b1, 1'b1, 1'b0, 13'h1FFF, 1'b0, 1'b0, 1'b0, 1);
        do_acc(1'b1, 1'b1, 1'b0, 13'h10F0, 1'b0, 1'b0, 1'b0, 1);
        acc_strobe = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(store_pulse == 1'b0 && recall_pulse == 1'b0, 1, "pulses after reset",
              int'({store_pulse, recall_pulse}), 0);
        do_acc(1'b1, 1'b1, 1'b0, 13'h0F0F, 1'b0, 1'b0, 1'b0, 1);

        // R10 / R2: back-to-back store runs each give one pulse, no recall
        for (int r = 0; r < 2; r++) begin
            do_acc(1'b1, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b0, 1'b0, 10);
            do_acc(1'b1, 1'b1, 1'b0, 13'h1555, 1'b0, 1'b0, 1'b0, 10);
            do_acc(1'b1, 1'b1, 1'b0, 13'h0AAA, 1'b0, 1'b0, 1'b0, 10);
            do_acc(1'b1, 1'b1, 1'b0, 13'h1FFF, 1'b0, 1'b0, 1'b0, 10);
            do_acc(1'b1, 1'b1, 1'b0, 13'h10F0, 1'b0, 1'b0, 1'b0, 10);
            do_acc(1'b1, 1'b1, 1'b0, 13'h0F0F, 1'b1, 1'b1, 1'b0, 2);
        end
        do_acc(1'b0, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b0, 1'b0, 10);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule